// File: doc/BRIEF.md
# Segment Address and Protection Checker

This unit turns a segment-relative offset into a linear address and decides whether the access is allowed. Each request carries a cached 64-bit segment descriptor, the 16-bit segment register value, a 32-bit offset, the kind of access (read, write or instruction fetch) and the addressing mode. The three modes are real, 16-bit protected and 32-bit protected. The unit returns the linear address together with a fault flag and a fault reason code.

In real mode the base comes from the segment register and the limit is fixed, so only the offset bound is checked. In the protected modes the unit takes the base, the limit, the granularity, the default-size flag and the access byte out of the descriptor. It then checks the offset against a limit that may be page-scaled or expand-down, and checks the access kind against the code or data rights of the segment.

All results are registered and appear one cycle after a request strobe. They hold their value until the next request. Comparison of privilege rings, paging and gate handling are left to other logic. A system descriptor is only reported as unusable.

Top module: `seg_xlate_unit`

## Requirements
- R1: `out_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. `lin_addr`, `fault` and `fault_code` change only in that cycle and hold otherwise. After reset all outputs are 0.
- R2: Real mode (`mode`=0) gives `lin_addr` = (`seg_sel` << 4) + `offset`. The descriptor and the access kind are ignored. The only possible fault is code 2, raised when `offset` > 0xFFFF.
- R3: Descriptor layout: bits 15:0 and 51:48 form the 20-bit limit. Bits 39:16 and 63:56 form the 32-bit base. Bits 47:40 are the access byte. Bit 55 is granularity and bit 54 is default size. In protected modes `lin_addr` = base + `offset` modulo 2^32, whether or not the access faults.
- R4: In 16-bit protected mode (`mode`=1), descriptor bits 63:48 are treated as zero. This gives a 24-bit base, a 16-bit byte-granular limit and default size 0.
- R5: When granularity is 1, the effective limit is {limit, 12'hFFF}. Otherwise the effective limit is the 20-bit limit zero-extended.
- R6: For code segments, and for data segments with access bit 2 clear, an offset above the effective limit raises code 2.
- R7: For a data segment with access bit 2 set (expand-down), the offset must be greater than the effective limit and at most the upper bound. The upper bound is 0xFFFF when default size is 0 and 0xFFFFFFFF when it is 1. Any other offset raises code 2.
- R8: In a protected mode, access bit 7 (present) clear raises code 1.
- R9: In a protected mode, access bit 4 clear (system descriptor) raises code 4.
- R10: Access bit 3 set marks a code segment, and access bit 1 is writable for data and readable for code. A write to a code segment, a write to a data segment with bit 1 clear, and a read of a code segment with bit 1 clear each raise code 3.
- R11: An execute access to a segment with access bit 3 clear raises code 3.
- R12: Priority is not-present over system over rights over limit. `fault` is 1 exactly when `fault_code` is not 0.
- R13: Encodings: `mode` 0 is real, 1 is 16-bit protected, 2 and 3 are 32-bit protected. `kind` 0 and 3 are read, 1 is write, 2 is execute. `fault_code` 0 means none, 1 not present, 2 limit, 3 rights, 4 system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| mode | input | 2 | Addressing mode |
| kind | input | 2 | Access kind |
| seg_sel | input | 16 | Segment register value |
| desc | input | 64 | Cached segment descriptor |
| offset | input | 32 | Offset within the segment |
| out_valid | output | 1 | Result strobe |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Access faults |
| fault_code | output | 3 | Fault reason |

## Verification
The bench probes the limit on both sides of every boundary:
- Offsets exactly at and one past a page-scaled limit. A design that forgot the 12 low one-bits would reject most of the last page.
- Expand-down segments at the limit, just above it, and past the 0xFFFF upper bound. A design that reused the expand-up comparison would accept exactly the offsets it must refuse.

It also targets these cases:
- A 16-bit descriptor whose top bytes are all ones. If those bytes leaked into the base, limit or flags, the linear address and limit verdict would change.
- Accesses that break several rules at once, which expose a wrong fault priority.
- A base plus offset that wraps past 2^32, which a wider adder would carry out of.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int SX_ADDR_W = 32;
   localparam int SX_DESC_W = 64;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_NP     = 3'd1,
      FLT_LIMIT  = 3'd2,
      FLT_RIGHTS = 3'd3,
      FLT_SYS    = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_READX = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic [SX_ADDR_W-1:0] base;
      logic [SX_ADDR_W-1:0] lim;
      logic [SX_ADDR_W-1:0] upper;
      logic                 expand_dn;
      logic                 present;
      logic                 is_seg;
      logic                 is_code;
      logic                 rw_ok;
      logic                 real_m;
   } seg_info_t;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W     = SX_ADDR_W,
   parameter int DESC_W     = SX_DESC_W,
   parameter int SEL_W      = 16,
   parameter int REAL_SHIFT = 4,
   parameter int PAGE_SHIFT = 12,
   parameter int LIM_W      = 20
) (
   input  logic [1:0]        mode,
   input  logic [SEL_W-1:0]  seg_sel,
   input  logic [DESC_W-1:0] desc,
   output seg_info_t         info
);
   localparam int REAL_PAD = ADDR_W - SEL_W - REAL_SHIFT;
   localparam int LIM_PAD  = ADDR_W - LIM_W;
   localparam logic [ADDR_W-1:0] SMALL_TOP = {{(ADDR_W-16){1'b0}}, 16'hFFFF};

   logic              wide;
   logic [7:0]        acc;
   logic [LIM_W-1:0]  raw_lim;
   logic [ADDR_W-1:0] lim_byte;
   logic [ADDR_W-1:0] lim_page;
   logic [ADDR_W-1:0] pm_base;
   logic              gran;
   logic              big;
   logic              unused_bits;

   assign wide    = mode[1];
   assign acc     = desc[47:40];
   assign raw_lim = {(wide ? desc[51:48] : 4'h0), desc[15:0]};
   assign gran    = wide & desc[55];
   assign big     = wide & desc[54];
   assign pm_base = {(wide ? desc[63:56] : 8'h00), desc[39:16]};
   assign lim_byte = {{LIM_PAD{1'b0}}, raw_lim};

   generate
      if (PAGE_SHIFT == LIM_PAD) begin : g_page_full
         assign lim_page = {raw_lim, {PAGE_SHIFT{1'b1}}};
      end else begin : g_page_part
         assign lim_page = (lim_byte << PAGE_SHIFT) | ((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));
      end
   endgenerate

   assign unused_bits = ^{acc[6:5], acc[0], desc[53:52]};

   always_comb begin
      info = '0;
      if (mode == 2'd0) begin
         info.base    = {{REAL_PAD{1'b0}}, seg_sel, {REAL_SHIFT{1'b0}}};
         info.lim     = SMALL_TOP;
         info.upper   = SMALL_TOP;
         info.present = 1'b1;
         info.is_seg  = 1'b1;
         info.rw_ok   = 1'b1;
         info.real_m  = 1'b1;
      end else begin
         info.base      = pm_base;
         info.lim       = gran ? lim_page : lim_byte;
         info.upper     = big ? '1 : SMALL_TOP;
         info.present   = acc[7];
         info.is_seg    = acc[4];
         info.is_code   = acc[3];
         info.expand_dn = ~acc[3] & acc[2];
         info.rw_ok     = acc[1];
      end
   end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] ofs,
   input  logic [ADDR_W-1:0] lim,
   input  logic [ADDR_W-1:0] upper,
   input  logic              expand_dn,
   output logic              lim_ok
);
   logic above_lim;
   logic below_top;

   assign above_lim = ofs > lim;
   assign below_top = ofs <= upper;
   assign lim_ok    = expand_dn ? (above_lim & below_top) : ~above_lim;
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
   import seg_xlate_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       is_code,
   input  logic       rw_ok,
   output logic       rights_ok
);
   always_comb begin
      unique case (acc_kind_e'(kind))
         ACC_WRITE: rights_ok = ~is_code & rw_ok;
         ACC_EXEC:  rights_ok = is_code;
         default:   rights_ok = ~is_code | rw_ok;
      endcase
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W     = SX_ADDR_W,
   parameter int DESC_W     = SX_DESC_W,
   parameter int SEL_W      = 16,
   parameter int REAL_SHIFT = 4,
   parameter int PAGE_SHIFT = 12,
   parameter int LIM_W      = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        mode,
   input  logic [1:0]        kind,
   input  logic [SEL_W-1:0]  seg_sel,
   input  logic [DESC_W-1:0] desc,
   input  logic [ADDR_W-1:0] offset,
   output logic              out_valid,
   output logic [ADDR_W-1:0] lin_addr,
   output logic              fault,
   output logic [2:0]        fault_code
);
   generate
      if (DESC_W != 64) begin : g_bad_desc
         $error("seg_xlate_unit: descriptor width must be 64");
      end
      if (ADDR_W != SX_ADDR_W) begin : g_bad_addr
         $error("seg_xlate_unit: address width must match package");
      end
      if (SEL_W + REAL_SHIFT > ADDR_W) begin : g_bad_real
         $error("seg_xlate_unit: real-mode base exceeds address width");
      end
      if (LIM_W + PAGE_SHIFT > ADDR_W) begin : g_bad_page
         $error("seg_xlate_unit: page-scaled limit exceeds address width");
      end
   endgenerate

   seg_info_t         info;
   logic              lim_ok;
   logic              rights_ok;
   fault_e            code_d;
   logic [ADDR_W-1:0] lin_d;

   seg_desc_decode #(
      .ADDR_W(ADDR_W), .DESC_W(DESC_W), .SEL_W(SEL_W),
      .REAL_SHIFT(REAL_SHIFT), .PAGE_SHIFT(PAGE_SHIFT), .LIM_W(LIM_W)
   ) i_decode (
      .mode(mode), .seg_sel(seg_sel), .desc(desc), .info(info)
   );

   seg_limit_chk #(.ADDR_W(ADDR_W)) i_limit (
      .ofs(offset), .lim(info.lim), .upper(info.upper),
      .expand_dn(info.expand_dn), .lim_ok(lim_ok)
   );

   seg_rights_chk i_rights (
      .kind(kind), .is_code(info.is_code), .rw_ok(info.rw_ok),
      .rights_ok(rights_ok)
   );

   assign lin_d = info.base + offset;

   always_comb begin
      if (info.real_m)          code_d = lim_ok ? FLT_NONE : FLT_LIMIT;
      else if (!info.present)   code_d = FLT_NP;
      else if (!info.is_seg)    code_d = FLT_SYS;
      else if (!rights_ok)      code_d = FLT_RIGHTS;
      else if (!lim_ok)         code_d = FLT_LIMIT;
      else                      code_d = FLT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         lin_addr   <= '0;
         fault      <= 1'b0;
         fault_code <= 3'd0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            lin_addr   <= lin_d;
            fault      <= (code_d != FLT_NONE);
            fault_code <= code_d;
         end
      end
   end
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [1:0]  mode,
   input logic [1:0]  kind,
   input logic [15:0] seg_sel,
   input logic [63:0] desc,
   input logic [31:0] offset,
   input logic        out_valid,
   input logic [31:0] lin_addr,
   input logic        fault,
   input logic [2:0]  fault_code
);
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && $stable(lin_addr) && $stable(fault_code) && $stable(fault)));

   p_real_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 2'd0) |=>
         (lin_addr == $past({12'b0, seg_sel, 4'b0} + offset)));

   p_real_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 2'd0) |=>
         (fault_code == ($past(offset) > 32'hFFFF ? 3'd2 : 3'd0)));

   p_not_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode != 2'd0 && !desc[47]) |=> (fault_code == 3'd1));

   p_system_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode != 2'd0 && desc[47] && !desc[44]) |=> (fault_code == 3'd4));

   p_exec_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode != 2'd0 && desc[47] && desc[44] && !desc[43] && kind == 2'd2)
         |=> (fault_code == 3'd3));

   p_write_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode != 2'd0 && desc[47] && desc[44] && desc[43] && kind == 2'd1)
         |=> (fault_code == 3'd3));

   p_flag_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (fault == (fault_code != 3'd0) && fault_code <= 3'd4));
endmodule

bind seg_xlate_unit seg_xlate_sva i_seg_xlate_sva (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  mode = '0;
   logic [1:0]  kind = '0;
   logic [15:0] seg_sel = '0;
   logic [63:0] desc = '0;
   logic [31:0] offset = '0;
   logic        out_valid;
   logic [31:0] lin_addr;
   logic        fault;
   logic [2:0]  fault_code;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlate_unit i_seg_xlate_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .kind(kind), .seg_sel(seg_sel), .desc(desc), .offset(offset),
      .out_valid(out_valid), .lin_addr(lin_addr), .fault(fault),
      .fault_code(fault_code)
   );

   function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                           input logic [7:0] acc, input logic g, input logic d);
      return {base[31:24], g, d, 2'b00, lim[19:16], acc, base[23:0], lim[15:0]};
   endfunction

   function automatic logic [31:0] eff_lim(input logic [1:0] m, input logic [63:0] dd);
      logic [19:0] l;
      if (m == 2'd0) return 32'hFFFF;
      l = (m == 2'd1) ? {4'h0, dd[15:0]} : {dd[51:48], dd[15:0]};
      if (m != 2'd1 && dd[55]) return {l, 12'hFFF};
      return {12'h000, l};
   endfunction

   // returns {code, linear address}
   function automatic logic [34:0] model(input logic [1:0] m, input logic [1:0] k,
                                         input logic [15:0] s, input logic [63:0] dd,
                                         input logic [31:0] o);
      logic [31:0] base, lim, top;
      logic [7:0]  a;
      logic        w, dn, ok_lim, ok_rt;
      logic [2:0]  c;
      w = (m != 2'd0 && m != 2'd1);
      a = dd[47:40];
      lim = eff_lim(m, dd);
      if (m == 2'd0) begin
         base = {12'h0, s, 4'h0};
         c = (o > 32'hFFFF) ? 3'd2 : 3'd0;
      end else begin
         base = {(w ? dd[63:56] : 8'h00), dd[39:16]};
         top  = (w && dd[54]) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
         dn   = !a[3] && a[2];
         ok_lim = dn ? (o > lim && o <= top) : (o <= lim);
         if (k == 2'd1)      ok_rt = !a[3] && a[1];
         else if (k == 2'd2) ok_rt = a[3];
         else                ok_rt = !a[3] || a[1];
         if (!a[7])        c = 3'd1;
         else if (!a[4])   c = 3'd4;
         else if (!ok_rt)  c = 3'd3;
         else if (!ok_lim) c = 3'd2;
         else              c = 3'd0;
      end
      return {c, base + o};
   endfunction

   task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] m, input logic [1:0] k, input logic [15:0] s,
                        input logic [63:0] dd, input logic [31:0] o);
      @(negedge clk);
      mode = m; kind = k; seg_sel = s; desc = dd; offset = o; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic dir_req(input string tag, input logic [1:0] m, input logic [1:0] k,
                          input logic [15:0] s, input logic [63:0] dd, input logic [31:0] o,
                          input logic [2:0] ec, input logic [31:0] ea);
      issue(m, k, s, dd, o);
      check_eq({tag, " valid R1"}, 64'(out_valid), 64'd1);
      check_eq({tag, " code"}, 64'(fault_code), 64'(ec));
      check_eq({tag, " flag R12"}, 64'(fault), 64'(ec != 3'd0));
      check_eq({tag, " addr"}, 64'(lin_addr), 64'(ea));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] dd;
      logic [34:0] ex;
      logic [31:0] hold_a;
      logic [2:0]  hold_c;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_eq("reset valid R1", 64'(out_valid), 64'd0);
      check_eq("reset outputs R1", {31'b0, fault, lin_addr}, 64'd0);
      check_eq("reset code R1", 64'(fault_code), 64'd0);
      rst_n = 1'b1;

      // real mode, descriptor ignored
      dir_req("R2 real wrap", 2'd0, 2'd1, 16'hFFFF, 64'd0, 32'h0000FFFF, 3'd0, 32'h0010FFEF);
      dir_req("R2 real past limit", 2'd0, 2'd2, 16'hFFFF, 64'd0, 32'h00010000, 3'd2, 32'h0010FFF0);
      dir_req("R2 real np desc", 2'd0, 2'd0, 16'h1234, 64'hFFFF_0000_0000_0000, 32'h10, 3'd0, 32'h00012350);

      // R1 hold: inputs change without strobe
      hold_a = lin_addr; hold_c = fault_code;
      @(negedge clk);
      mode = 2'd2; offset = 32'hDEAD_BEEF; desc = '0;
      @(negedge clk);
      @(negedge clk);
      check_eq("R1 idle valid low", 64'(out_valid), 64'd0);
      check_eq("R1 idle addr held", 64'(lin_addr), 64'(hold_a));
      check_eq("R1 idle code held", 64'(fault_code), 64'(hold_c));

      // R3 R5 granularity
      dd = mk_desc(32'h1000_0000, 20'h00001, 8'h92, 1'b1, 1'b0);
      dir_req("R5 page last", 2'd2, 2'd1, 16'h0, dd, 32'h0000_1FFF, 3'd0, 32'h1000_1FFF);
      dir_req("R5 page past R6", 2'd2, 2'd0, 16'h0, dd, 32'h0000_2000, 3'd2, 32'h1000_2000);
      dd = mk_desc(32'h1000_0000, 20'h00001, 8'h92, 1'b0, 1'b0);
      dir_req("R6 byte past", 2'd2, 2'd0, 16'h0, dd, 32'h0000_0002, 3'd2, 32'h1000_0002);
      dd = mk_desc(32'hFFFF_F000, 20'hFFFFF, 8'h92, 1'b1, 1'b1);
      dir_req("R3 base wrap", 2'd2, 2'd0, 16'h0, dd, 32'h0000_2000, 3'd0, 32'h0000_1000);

      // R7 expand-down
      dd = mk_desc(32'h0, 20'h00FFF, 8'h96, 1'b0, 1'b0);
      dir_req("R7 dn at limit", 2'd2, 2'd0, 16'h0, dd, 32'h0000_0FFF, 3'd2, 32'h0000_0FFF);
      dir_req("R7 dn above", 2'd2, 2'd1, 16'h0, dd, 32'h0000_1000, 3'd0, 32'h0000_1000);
      dir_req("R7 dn small top", 2'd2, 2'd0, 16'h0, dd, 32'h0001_0000, 3'd2, 32'h0001_0000);
      dd = mk_desc(32'h0, 20'h00FFF, 8'h96, 1'b0, 1'b1);
      dir_req("R7 dn big top", 2'd2, 2'd0, 16'h0, dd, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_FFFF);

      // R8 R9 R10 R11 R12
      dd = mk_desc(32'h0, 20'hFFFFF, 8'h9A, 1'b0, 1'b0);
      dir_req("R10 write code", 2'd2, 2'd1, 16'h0, dd, 32'h10, 3'd3, 32'h10);
      dir_req("R10 read code ok", 2'd2, 2'd0, 16'h0, dd, 32'h10, 3'd0, 32'h10);
      dd = mk_desc(32'h0, 20'h00010, 8'h98, 1'b0, 1'b0);
      dir_req("R10 read exec-only", 2'd2, 2'd0, 16'h0, dd, 32'h4, 3'd3, 32'h4);
      dir_req("R13 kind3 as read", 2'd2, 2'd3, 16'h0, dd, 32'h4, 3'd3, 32'h4);
      dir_req("R12 rights over limit", 2'd2, 2'd1, 16'h0, dd, 32'h100, 3'd3, 32'h100);
      dd = mk_desc(32'h0, 20'h00010, 8'h90, 1'b0, 1'b0);
      dir_req("R10 write readonly", 2'd2, 2'd1, 16'h0, dd, 32'h4, 3'd3, 32'h4);
      dd = mk_desc(32'h0, 20'h00010, 8'h92, 1'b0, 1'b0);
      dir_req("R11 exec data", 2'd2, 2'd2, 16'h0, dd, 32'h4, 3'd3, 32'h4);
      dd = mk_desc(32'h0, 20'h00010, 8'h89, 1'b0, 1'b0);
      dir_req("R9 system", 2'd2, 2'd0, 16'h0, dd, 32'h4, 3'd4, 32'h4);
      dd = mk_desc(32'h0, 20'h00010, 8'h09, 1'b0, 1'b0);
      dir_req("R8 R12 np over sys", 2'd1, 2'd0, 16'h0, dd, 32'h400, 3'd1, 32'h400);

      // R4 top bytes ignored in 16-bit mode, R13 mode 3 as 32-bit
      dd = {16'hFFFF, 8'h92, 24'h123456, 16'h00FF};
      dir_req("R4 p16 top ignored", 2'd1, 2'd0, 16'h0, dd, 32'h100, 3'd2, 32'h0012_3556);
      dir_req("R13 mode3 wide", 2'd3, 2'd0, 16'h0, dd, 32'h100, 3'd0, 32'hFF12_3556);
      dd = {16'hFFFF, 8'h96, 24'h0, 16'h00FF};
      dir_req("R4 p16 dn top", 2'd1, 2'd0, 16'h0, dd, 32'h10000, 3'd2, 32'h10000);

      // constrained random against the model
      for (int i = 0; i < 3000; i++) begin
         logic [1:0]  m, k;
         logic [7:0]  a;
         logic [31:0] o, l;
         m = 2'($urandom_range(0, 3));
         k = 2'($urandom_range(0, 3));
         a = 8'($urandom);
         if ($urandom_range(0, 7) != 0) a[7] = 1'b1;
         if ($urandom_range(0, 7) != 0) a[4] = 1'b1;
         dd = mk_desc($urandom, 20'($urandom), a, 1'($urandom), 1'($urandom));
         if ($urandom_range(0, 3) == 0) dd[63:48] = 16'hFFFF;
         l = eff_lim(m, dd);
         case ($urandom_range(0, 3))
            0: o = $urandom;
            1: o = l + 32'($urandom_range(0, 4)) - 32'd2;
            2: o = 32'h0000_FFFF + 32'($urandom_range(0, 2)) - 32'd1;
            default: o = 32'($urandom_range(0, 255));
         endcase
         issue(m, k, 16'($urandom), dd, o);
         ex = model(mode, kind, seg_sel, desc, offset);
         check_eq("R3 R6 R7 R10 random code", 64'(fault_code), 64'(ex[34:32]));
         check_eq("R3 random addr", 64'(lin_addr), 64'(ex[31:0]));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule